// File: doc/BRIEF.md
# Attribute Palette Controller

This block sits between the pixel pipeline and a colour look-up DAC. It turns each pixel attribute into an 8-bit DAC address. In the palette modes, the low four attribute bits pick one of sixteen 6-bit palette entries. A colour-select register then supplies the upper DAC address bits, and either two or four of its bits are used. In the linear 256-colour mode, the full 8-bit attribute becomes the DAC address unchanged, and neither the palette nor the colour select takes part.

Software reaches the registers through one write port. A phase flag decides whether each write is an index or a data value. A dedicated clear strobe forces the flag back to the index phase, so software can always resynchronise before an access. A read port with a select line returns either the current index or the register that the index points at. Reads never move the phase flag.

Pixels enter on a valid/ready stream and DAC addresses leave on another. A single output register sits between them. The input accepts a beat whenever the output register is empty, or is being drained in the same cycle. An address that has been presented stays frozen until the consumer takes it. The mapping uses the register contents of the cycle in which the pixel is accepted.

Top module: `attr_palette_ctrl`

## Requirements
- R1: After reset, the write phase is index, all palette entries, the mode byte and the colour select read as zero, `dac_valid` is 0, `pix_ready` is 1 and `pan_compat` is 0.
- R2: After a clear, the first write loads the 8-bit index and moves the phase to data. The next write stores data and returns the phase to index, so index and data writes alternate.
- R3: A `flag_clr` pulse returns the phase to index. If `cpu_wr` is high in the same cycle, that write is taken as an index write and the phase moves to data.
- R4: A read (`cpu_rd`=1) presents its value on `cpu_rdata` in the following cycle and does not change the phase. With `cpu_rd_sel`=0 it returns the index. With `cpu_rd_sel`=1 it returns the indexed register zero-extended.
- R5: Index values 0 to 15 address the palette entries, which take data bits 5:0. Index 16 is the mode byte (8 bits). Index 17 is the colour select, which takes data bits 3:0. Data writes to any other index change nothing, and reads of such an index return 0.
- R6: When mode bit 6 is 0 and mode bit 7 is 1, the DAC address is the colour select bits 3:0 followed by bits 3:0 of the palette entry selected by attribute bits 3:0.
- R7: When mode bit 6 is 0 and mode bit 7 is 0, the DAC address is colour select bits 3:2 followed by bits 5:0 of the selected palette entry.
- R8: When mode bit 6 is 1, the DAC address equals the 8-bit attribute, whatever the colour select, mode bit 7 and the palette hold.
- R9: `pan_compat` follows mode bit 5.
- R10: `pix_ready` is high whenever `dac_valid` is low or `dac_ready` is high. An accepted pixel appears on `dac_addr` with `dac_valid` high in the next cycle. While `dac_valid` is high and `dac_ready` is low, `dac_addr` and `dac_valid` hold.
- R11: A held output does not change when the registers are written after its pixel was accepted. The next pixel uses the registers as they stand when it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_clr | input | 1 | Forces the write phase to index |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write value (index or data by phase) |
| cpu_rd | input | 1 | Register read strobe |
| cpu_rd_sel | input | 1 | 0 reads the index, 1 reads the indexed register |
| cpu_rdata | output | 8 | Read result, valid the cycle after `cpu_rd` |
| pix_valid | input | 1 | Pixel attribute valid |
| pix_ready | output | 1 | Block can accept a pixel |
| pix_attr | input | 8 | Pixel attribute |
| dac_valid | output | 1 | DAC address valid |
| dac_ready | input | 1 | Consumer takes the DAC address |
| dac_addr | output | 8 | DAC address |
| pan_compat | output | 1 | Pan-compatibility enable for the panning unit |

## Verification
The assertions assume reset is applied before the first stream or register activity. They also assume that `cpu_wdata` and `pix_attr` carry known values in any cycle where `cpu_wr` or an accepted pixel uses them, and that the attribute and DAC widths match.

The stimulus drives every input on the falling clock edge. It holds `pix_valid` and the attribute steady until the beat is accepted, and it only presents register data together with a write strobe. The back-pressure case keeps `dac_ready` low across several register writes, so the frozen-output property is exercised while the colour select changes underneath it.

// File: rtl/attr_pkg.sv
package attr_pkg;

  // Phase of the shared index/data write port
  typedef enum logic {
    PH_INDEX = 1'b0,
    PH_DATA  = 1'b1
  } phase_t;

  // Bit positions inside the mode byte
  localparam int MODE_CS4_BIT = 7;  // 1: four colour-select bits, 0: two
  localparam int MODE_LIN_BIT = 6;  // 1: attribute drives DAC directly
  localparam int MODE_PAN_BIT = 5;  // pan-compatibility enable

endpackage

// File: rtl/attr_port_seq.sv
module attr_port_seq
  import attr_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_clr,
  input  logic             cpu_wr,
  input  logic [IDX_W-1:0] cpu_wdata,
  output logic [IDX_W-1:0] idx_q,
  output logic             data_we
);

  phase_t phase_q;
  phase_t phase_eff;

  // the clear acts ahead of a write in the same cycle
  always_comb phase_eff = flag_clr ? PH_INDEX : phase_q;

  assign data_we = cpu_wr && (phase_eff == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INDEX;
      idx_q   <= '0;
    end else if (cpu_wr) begin
      if (phase_eff == PH_INDEX) begin
        idx_q   <= cpu_wdata;
        phase_q <= PH_DATA;
      end else begin
        phase_q <= PH_INDEX;
      end
    end else if (flag_clr) begin
      phase_q <= PH_INDEX;
    end
  end

  // R2
  wr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && !flag_clr |=> phase_q != $past(phase_q));

  // R3
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !cpu_wr |=> phase_q == PH_INDEX);

  // R3
  clr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && cpu_wr |=> (phase_q == PH_DATA) && (idx_q == $past(cpu_wdata)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr && !flag_clr |=> $stable(phase_q) && $stable(idx_q));

endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
  import attr_pkg::*;
#(
  parameter int PAL_DEPTH = 16,
  parameter int PAL_W     = 6,
  parameter int DW        = 8,
  parameter int CS_W      = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [DW-1:0]                   idx,
  input  logic                            data_we,
  input  logic [DW-1:0]                   wdata,
  input  logic                            rd_en,
  input  logic                            rd_sel,
  output logic [DW-1:0]                   rd_data,
  output logic [PAL_DEPTH-1:0][PAL_W-1:0] pal_o,
  output logic [CS_W-1:0]                 csel_o,
  output logic                            cs_wide,
  output logic                            linear,
  output logic                            pan_en
);

  localparam int SEL_W    = $clog2(PAL_DEPTH);
  localparam int MODE_IDX = PAL_DEPTH;
  localparam int CSEL_IDX = PAL_DEPTH + 1;

  logic [DW-1:0]   mode_q;
  logic [CS_W-1:0] csel_q;
  logic [DW-1:0]   data_view;

  // one storage register per palette entry
  for (genvar g = 0; g < PAL_DEPTH; g++) begin : g_entry
    logic [PAL_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ent_q <= '0;
      else if (data_we && idx == DW'(g))   ent_q <= wdata[PAL_W-1:0];
    end
    assign pal_o[g] = ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      csel_q <= '0;
    end else if (data_we) begin
      if (idx == DW'(MODE_IDX)) mode_q <= wdata;
      if (idx == DW'(CSEL_IDX)) csel_q <= wdata[CS_W-1:0];
    end
  end

  always_comb begin
    data_view = '0;
    if (idx < DW'(PAL_DEPTH))      data_view = DW'(pal_o[idx[SEL_W-1:0]]);
    else if (idx == DW'(MODE_IDX)) data_view = mode_q;
    else if (idx == DW'(CSEL_IDX)) data_view = DW'(csel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_sel ? data_view : idx;
  end

  assign csel_o  = csel_q;
  assign cs_wide = mode_q[MODE_CS4_BIT];
  assign linear  = mode_q[MODE_LIN_BIT];
  assign pan_en  = mode_q[MODE_PAN_BIT];

  // R5
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_we && (idx > DW'(CSEL_IDX)) |=> $stable(mode_q) && $stable(csel_q));

  // R5
  csel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(csel_q) && $stable(mode_q));

endmodule

// File: rtl/attr_dac_map.sv
module attr_dac_map #(
  parameter int ATTR_W    = 8,
  parameter int DAC_W     = 8,
  parameter int PAL_DEPTH = 16,
  parameter int PAL_W     = 6,
  parameter int CS_W      = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            pix_valid,
  output logic                            pix_ready,
  input  logic [ATTR_W-1:0]               pix_attr,
  output logic                            dac_valid,
  input  logic                            dac_ready,
  output logic [DAC_W-1:0]                dac_addr,
  input  logic [PAL_DEPTH-1:0][PAL_W-1:0] pal,
  input  logic [CS_W-1:0]                 csel,
  input  logic                            cs_wide,
  input  logic                            linear
);

  localparam int SEL_W   = $clog2(PAL_DEPTH);
  localparam int LOW_W4  = DAC_W - CS_W;  // entry bits kept with four select bits
  localparam int LOW_W2  = DAC_W - 2;     // entry bits kept with two select bits

  logic             take;
  logic [PAL_W-1:0] entry;
  logic [DAC_W-1:0] mapped;

  assign pix_ready = !dac_valid || dac_ready;
  assign take      = pix_valid && pix_ready;
  assign entry     = pal[pix_attr[SEL_W-1:0]];

  always_comb begin
    if (linear)       mapped = DAC_W'(pix_attr);
    else if (cs_wide) mapped = {csel, entry[LOW_W4-1:0]};
    else              mapped = {csel[CS_W-1:CS_W-2], entry[LOW_W2-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_valid <= 1'b0;
      dac_addr  <= '0;
    end else if (take) begin
      dac_valid <= 1'b1;
      dac_addr  <= mapped;
    end else if (dac_ready) begin
      dac_valid <= 1'b0;
    end
  end

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid && !dac_ready |=> dac_valid && $stable(dac_addr));

  // R10
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready |=> dac_valid);

  // R8
  linear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && linear |=> dac_addr == DAC_W'($past(pix_attr)));

  // R6
  wide_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !linear && cs_wide |=> dac_addr[DAC_W-1:LOW_W4] == $past(csel));

  // R7
  narrow_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !linear && !cs_wide |=> dac_addr[DAC_W-1:LOW_W2] == $past(csel[CS_W-1:CS_W-2]));

endmodule

// File: rtl/attr_palette_ctrl.sv
module attr_palette_ctrl #(
  parameter int PAL_DEPTH = 16,
  parameter int PAL_W     = 6,
  parameter int CS_W      = 4,
  parameter int DW        = 8,
  parameter int ATTR_W    = 8,
  parameter int DAC_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_clr,
  input  logic              cpu_wr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_rd_sel,
  output logic [DW-1:0]     cpu_rdata,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [ATTR_W-1:0] pix_attr,
  output logic              dac_valid,
  input  logic              dac_ready,
  output logic [DAC_W-1:0]  dac_addr,
  output logic              pan_compat
);

  logic [DW-1:0]                   idx_q;
  logic                            data_we;
  logic [PAL_DEPTH-1:0][PAL_W-1:0] pal;
  logic [CS_W-1:0]                 csel;
  logic                            cs_wide;
  logic                            linear;

  attr_port_seq #(.IDX_W(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_clr  (flag_clr),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .idx_q     (idx_q),
    .data_we   (data_we)
  );

  attr_regfile #(
    .PAL_DEPTH (PAL_DEPTH),
    .PAL_W     (PAL_W),
    .DW        (DW),
    .CS_W      (CS_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (idx_q),
    .data_we (data_we),
    .wdata   (cpu_wdata),
    .rd_en   (cpu_rd),
    .rd_sel  (cpu_rd_sel),
    .rd_data (cpu_rdata),
    .pal_o   (pal),
    .csel_o  (csel),
    .cs_wide (cs_wide),
    .linear  (linear),
    .pan_en  (pan_compat)
  );

  attr_dac_map #(
    .ATTR_W    (ATTR_W),
    .DAC_W     (DAC_W),
    .PAL_DEPTH (PAL_DEPTH),
    .PAL_W     (PAL_W),
    .CS_W      (CS_W)
  ) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_attr  (pix_attr),
    .dac_valid (dac_valid),
    .dac_ready (dac_ready),
    .dac_addr  (dac_addr),
    .pal       (pal),
    .csel      (csel),
    .cs_wide   (cs_wide),
    .linear    (linear)
  );

  // R10
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_valid |-> pix_ready);

endmodule

// File: tb/attr_palette_ctrl_bench.sv
module attr_palette_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flag_clr = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_rd = 1'b0;
  logic       cpu_rd_sel = 1'b0;
  logic [7:0] cpu_rdata;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [7:0] pix_attr = '0;
  logic       dac_valid;
  logic       dac_ready = 1'b1;
  logic [7:0] dac_addr;
  logic       pan_compat;

  int checks = 0;
  int bad = 0;

  logic [5:0] pal_m [16];
  logic [7:0] mode_m = '0;
  logic [3:0] cs_m = '0;

  always #5 clk = ~clk;

  attr_palette_ctrl u_attr_palette_ctrl (
    .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rd_sel(cpu_rd_sel),
    .cpu_rdata(cpu_rdata), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_attr(pix_attr), .dac_valid(dac_valid), .dac_ready(dac_ready),
    .dac_addr(dac_addr), .pan_compat(pan_compat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] v);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = v;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic sel, output logic [7:0] v);
    @(negedge clk); cpu_rd = 1'b1; cpu_rd_sel = sel;
    @(negedge clk); cpu_rd = 1'b0; v = cpu_rdata;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
    cpu_write(i); cpu_write(v);
    if (i < 8'd16) pal_m[i[3:0]] = v[5:0];
    else if (i == 8'd16) mode_m = v;
    else if (i == 8'd17) cs_m = v[3:0];
  endtask

  task automatic read_reg(input logic [7:0] i, output logic [7:0] v);
    cpu_write(i); cpu_read(1'b1, v); pulse_clr();
  endtask

  function automatic logic [7:0] exp_addr(input logic [7:0] a, input logic [7:0] m,
                                          input logic [3:0] cs);
    logic [5:0] p;
    p = pal_m[a[3:0]];
    if (m[6])      return a;
    else if (m[7]) return {cs, p[3:0]};
    else           return {cs[3:2], p};
  endfunction

  task automatic load_pal(input int seed);
    for (int i = 0; i < 16; i++) set_reg(8'(i), 8'((i * 11 + seed * 7 + 1) & 63));
  endtask

  // streams all 256 attributes back to back with the consumer always ready
  task automatic sweep(input string tag);
    dac_ready = 1'b1;
    @(negedge clk); pix_valid = 1'b1; pix_attr = 8'd0;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      chk({tag, " valid"}, 32'(dac_valid), 32'd1);
      chk({tag, " addr"}, 32'(dac_addr), 32'(exp_addr(8'(a), mode_m, cs_m)));
      if (a < 255) pix_attr = 8'(a + 1);
      else pix_valid = 1'b0;
    end
    @(negedge clk);
    chk({tag, " drained"}, 32'(dac_valid), 32'd0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; bad++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 16; i++) pal_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 dac_valid", 32'(dac_valid), 0);
    chk("R1 pix_ready", 32'(pix_ready), 1);
    chk("R1 pan_compat", 32'(pan_compat), 0);
    cpu_read(1'b0, v); chk("R1 index", 32'(v), 0);
    cpu_read(1'b1, v); chk("R1 entry0", 32'(v), 0);
    read_reg(8'd16, v); chk("R1 mode", 32'(v), 0);
    read_reg(8'd17, v); chk("R1 csel", 32'(v), 0);

    // R2 alternation: index, data, index, data
    cpu_write(8'd16); cpu_write(8'h80); cpu_write(8'd17); cpu_write(8'h03);
    mode_m = 8'h80; cs_m = 4'h3;
    read_reg(8'd16, v); chk("R2 mode", 32'(v), 32'h80);
    read_reg(8'd17, v); chk("R2 csel", 32'(v), 32'h03);

    // R4 reads keep the phase; data read zero-extends
    load_pal(1);
    cpu_write(8'd7);
    cpu_read(1'b0, v); chk("R4 index read", 32'(v), 7);
    cpu_read(1'b1, v); chk("R4 data read", 32'(v), 32'(pal_m[7]));
    cpu_read(1'b0, v); chk("R4 index reread", 32'(v), 7);
    cpu_write(8'hEA); pal_m[7] = 6'h2A;
    read_reg(8'd7, v); chk("R4 data landed", 32'(v), 32'h2A);

    // R3 clear after an index write
    cpu_write(8'd3); pulse_clr();
    cpu_write(8'd5); cpu_write(8'h11); pal_m[5] = 6'h11;
    read_reg(8'd5, v); chk("R3 new index", 32'(v), 32'h11);
    read_reg(8'd3, v); chk("R3 old untouched", 32'(v), 32'(pal_m[3]));
    // R3 clear and write together
    cpu_write(8'd4);
    @(negedge clk); flag_clr = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'd6;
    @(negedge clk); flag_clr = 1'b0; cpu_wr = 1'b0;
    cpu_write(8'h15); pal_m[6] = 6'h15;
    read_reg(8'd6, v); chk("R3 same-cycle entry6", 32'(v), 32'h15);
    read_reg(8'd4, v); chk("R3 same-cycle entry4", 32'(v), 32'(pal_m[4]));

    // R5 stray index
    cpu_write(8'd20); cpu_write(8'hFF);
    read_reg(8'd20, v); chk("R5 stray read", 32'(v), 0);
    read_reg(8'd16, v); chk("R5 mode kept", 32'(v), 32'(mode_m));
    read_reg(8'd17, v); chk("R5 csel kept", 32'(v), 32'(cs_m));
    cpu_write(8'd17); cpu_write(8'hF9); cs_m = 4'h9;
    read_reg(8'd17, v); chk("R5 csel width", 32'(v), 32'h09);

    // R6 wide colour select sweeps, with R9 pan bit set
    set_reg(8'd16, 8'hA0);
    @(negedge clk); chk("R9 pan on", 32'(pan_compat), 1);
    for (int c = 0; c < 16; c++) begin
      set_reg(8'd17, 8'(c));
      sweep("R6");
    end

    // R7 narrow colour select sweeps
    load_pal(5);
    set_reg(8'd16, 8'h00);
    @(negedge clk); chk("R9 pan off", 32'(pan_compat), 0);
    for (int c = 0; c < 16; c++) begin
      set_reg(8'd17, 8'(c));
      sweep("R7");
    end

    // R8 linear mode ignores palette and colour select
    set_reg(8'd16, 8'h40); set_reg(8'd17, 8'h0F); sweep("R8");
    set_reg(8'd16, 8'hE0); set_reg(8'd17, 8'h00); sweep("R8");
    chk("R9 pan linear", 32'(pan_compat), 1);

    // R10 / R11 back-pressure with a register change under a held output
    set_reg(8'd16, 8'h80); set_reg(8'd17, 8'h05);
    @(negedge clk); dac_ready = 1'b0; pix_valid = 1'b1; pix_attr = 8'h03;
    @(negedge clk); pix_attr = 8'h39;
    chk("R10 held valid", 32'(dac_valid), 1);
    chk("R10 ready low", 32'(pix_ready), 0);
    chk("R10 first addr", 32'(dac_addr), 32'(exp_addr(8'h03, 8'h80, 4'h5)));
    set_reg(8'd17, 8'h0A);
    chk("R11 held addr", 32'(dac_addr), 32'(exp_addr(8'h03, 8'h80, 4'h5)));
    chk("R10 still ready low", 32'(pix_ready), 0);
    dac_ready = 1'b1;
    @(negedge clk); pix_valid = 1'b0;
    chk("R11 second addr", 32'(dac_addr), 32'(exp_addr(8'h39, 8'h80, 4'hA)));
    @(negedge clk);
    chk("R10 drained", 32'(dac_valid), 0);
    chk("R10 ready back", 32'(pix_ready), 1);

    finish_run();
  end

endmodule